// File: doc/BRIEF.md
# Spread-Spectrum Packet Header Framer

This block produces the serial bit stream that opens every transmitted packet: a run of all-ones synchronisation bits followed by a header whose fields depend on a two-bit protocol mode. The stream is handed, one bit at a time, to a downstream modulator that paces it with a ready signal. When the last header bit has been taken, the block raises a one-cycle completion strobe. The payload path then takes over.

A start strobe given while the framer is idle captures the whole configuration at once, so the configuration inputs may change freely while a header is in flight. In the richer modes the block protects the header fields with a CCITT CRC-16. It computes the CRC serially as the bits leave and sends its complement as the last field. The value sent is also kept on a status output until a later header replaces it.

Top module: `hdr_framer`

## Requirements
- R1: After reset `bit_valid` and `hdr_done` are 0 and `crc_status` is 16'h0000.
- R2: A `start` seen while idle captures every `cfg_*` input and begins a header on the next cycle. Changes to `cfg_*` after that cycle do not alter the header being sent.
- R3: The header opens with `cfg_pre_len` one-bits (0 to 256). A length of 0 skips the preamble entirely.
- R4: The fields after the preamble, in sending order, depend on `cfg_mode`. Mode 0 sends SFD. Mode 1 sends SFD, CRC. Mode 2 sends SFD, length, CRC. Mode 3 sends SFD, signal, service, length, CRC. SFD (16 bits), signal (8), service (8) and length (16) are each sent least significant bit first.
- R5: The signal field is `cfg_sig_dbpsk` when `cfg_mod_sel` is 0 and `cfg_sig_dqpsk` when it is 1.
- R6: The CRC field (16 bits) is the ones complement of a CRC-16 with polynomial x^16+x^12+x^5+1. The CRC is preset to 16'hFFFF and fed every header bit after the preamble and before the CRC, in sending order. It is sent most significant bit first.
- R7: A bit is accepted only in a cycle where `bit_valid` and `bit_ready` are both 1. Otherwise `bit_out` and `bit_valid` hold.
- R8: `hdr_done` is 1 for exactly one cycle, the cycle after the last header bit is accepted, and `bit_valid` is 0 in that cycle.
- R9: `start` while a header is in flight, including the cycle in which its last bit is accepted, is ignored.
- R10: `crc_status` shows the CRC field of the most recent header that carried one, from the `hdr_done` cycle on. A mode 0 header leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Protocol mode 0..3 |
| cfg_pre_len | input | 9 | Preamble length in bits, 0..256 |
| cfg_sfd | input | 16 | Start-of-frame delimiter value |
| cfg_sig_dbpsk | input | 8 | Signal code for DBPSK payload |
| cfg_sig_dqpsk | input | 8 | Signal code for DQPSK payload |
| cfg_mod_sel | input | 1 | Payload modulation select, 0 = DBPSK, 1 = DQPSK |
| cfg_service | input | 8 | Service field value |
| cfg_length | input | 16 | Length field value |
| start | input | 1 | Begin a header (honoured only when idle) |
| bit_ready | input | 1 | Downstream accepts the current bit |
| bit_out | output | 1 | Current header bit |
| bit_valid | output | 1 | A header bit is being offered |
| hdr_done | output | 1 | One-cycle pulse after the last header bit |
| crc_status | output | 16 | CRC field of the latest header that had one |

## Verification
Two events can fall in the same cycle: a fresh `start` and the acceptance of the last bit of the current header. The bench provokes this on every header by raising `start` exactly in the cycle where it also raises `bit_ready` for the final bit. It then judges the outcome at the ports. The following cycle must show `hdr_done` with `bit_valid` low, and the cycle after must still be idle. A bench that only pulses `start` after `hdr_done` would never expose a framer that re-arms on the closing transfer. The sweep covers every mode, both modulation selects, several preamble lengths and three ready patterns, with the configuration scrambled after each start.

// File: rtl/hf_pkg.sv
package hf_pkg;

  localparam int SFD_W  = 16;
  localparam int SIG_W  = 8;
  localparam int SVC_W  = 8;
  localparam int LEN_W  = 16;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [2:0] {
    F_IDLE, F_PRE, F_SFD, F_SIG, F_SVC, F_LEN, F_CRC
  } field_e;

  // Field that follows f in the given protocol mode.
  function automatic field_e next_field(field_e f, logic [1:0] mode);
    case (f)
      F_PRE: return F_SFD;
      F_SFD: begin
        case (mode)
          2'd0:    return F_IDLE;
          2'd1:    return F_CRC;
          2'd2:    return F_LEN;
          default: return F_SIG;
        endcase
      end
      F_SIG:   return F_SVC;
      F_SVC:   return F_LEN;
      F_LEN:   return F_CRC;
      default: return F_IDLE;
    endcase
  endfunction

  // Width in bits of a fixed-size header field.
  function automatic logic [8:0] fixed_len(field_e f);
    case (f)
      F_SFD:   return 9'(SFD_W);
      F_SIG:   return 9'(SIG_W);
      F_SVC:   return 9'(SVC_W);
      F_LEN:   return 9'(LEN_W);
      F_CRC:   return 9'(CRC_W);
      default: return 9'd1;
    endcase
  endfunction

  // One serial CRC step, MSB-side feedback.
  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  // Protected fields: everything after the preamble up to the CRC.
  function automatic logic is_protected(field_e f);
    return (f == F_SFD) || (f == F_SIG) || (f == F_SVC) || (f == F_LEN);
  endfunction

endpackage

// File: rtl/hf_crc_unit.sv
module hf_crc_unit
  import hf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             din,
  output logic [CRC_W-1:0] crc_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_SEED;
    else if (clear)  crc_q <= CRC_SEED;
    else if (step)   crc_q <= crc_step(crc_q, din);
  end

  // R6: the remainder only moves on a protected-bit step or a new header
  a_r6_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step) |=> $stable(crc_q));

endmodule

// File: rtl/hf_bit_mux.sv
module hf_bit_mux
  import hf_pkg::*;
(
  input  field_e           field,
  input  logic [3:0]       idx,
  input  logic [SFD_W-1:0] sfd,
  input  logic [SIG_W-1:0] sig,
  input  logic [SVC_W-1:0] svc,
  input  logic [LEN_W-1:0] len,
  input  logic [CRC_W-1:0] crc,
  output logic             bit_o
);

  always_comb begin
    case (field)
      F_PRE:   bit_o = 1'b1;
      F_SFD:   bit_o = sfd[idx];
      F_SIG:   bit_o = sig[idx[2:0]];
      F_SVC:   bit_o = svc[idx[2:0]];
      F_LEN:   bit_o = len[idx];
      F_CRC:   bit_o = ~crc[4'(CRC_W-1) - idx];
      default: bit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/hdr_framer.sv
module hdr_framer
  import hf_pkg::*;
#(
  parameter int PRE_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [PRE_W-1:0] cfg_pre_len,
  input  logic [SFD_W-1:0] cfg_sfd,
  input  logic [SIG_W-1:0] cfg_sig_dbpsk,
  input  logic [SIG_W-1:0] cfg_sig_dqpsk,
  input  logic             cfg_mod_sel,
  input  logic [SVC_W-1:0] cfg_service,
  input  logic [LEN_W-1:0] cfg_length,
  input  logic             start,
  input  logic             bit_ready,
  output logic             bit_out,
  output logic             bit_valid,
  output logic             hdr_done,
  output logic [CRC_W-1:0] crc_status
);

  localparam int IDX_W = (PRE_W > 5) ? PRE_W : 5;

  field_e             field_q;
  logic [IDX_W-1:0]   idx_q;
  logic [1:0]         mode_q;
  logic [PRE_W-1:0]   pre_q;
  logic [SFD_W-1:0]   sfd_q;
  logic [SIG_W-1:0]   sig_q;
  logic [SVC_W-1:0]   svc_q;
  logic [LEN_W-1:0]   len_q;
  logic               done_q;
  logic [CRC_W-1:0]   stat_q;
  logic [CRC_W-1:0]   crc_q;

  // Named internal events
  logic               idle;
  logic               launch;
  logic               xfer;
  logic               field_end;
  logic               last_bit;
  logic [IDX_W-1:0]   cur_len;
  field_e             nxt_field;
  logic               mux_bit;

  assign idle      = (field_q == F_IDLE);
  assign launch    = idle && start;
  assign xfer      = !idle && bit_ready;
  assign cur_len   = (field_q == F_PRE) ? IDX_W'(pre_q) : IDX_W'(fixed_len(field_q));
  assign field_end = (idx_q == cur_len - 1'b1);
  assign nxt_field = next_field(field_q, mode_q);
  assign last_bit  = xfer && field_end && (nxt_field == F_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= F_IDLE;
      idx_q   <= '0;
      mode_q  <= '0;
      pre_q   <= '0;
      sfd_q   <= '0;
      sig_q   <= '0;
      svc_q   <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
      stat_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        mode_q  <= cfg_mode;
        pre_q   <= cfg_pre_len;
        sfd_q   <= cfg_sfd;
        sig_q   <= cfg_mod_sel ? cfg_sig_dqpsk : cfg_sig_dbpsk;
        svc_q   <= cfg_service;
        len_q   <= cfg_length;
        idx_q   <= '0;
        field_q <= (cfg_pre_len == '0) ? F_SFD : F_PRE;
      end else if (xfer) begin
        if (field_end) begin
          idx_q   <= '0;
          field_q <= nxt_field;
          if (field_q == F_CRC) stat_q <= ~crc_q;
          if (last_bit) done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  hf_crc_unit u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (launch),
    .step  (xfer && is_protected(field_q)),
    .din   (mux_bit),
    .crc_q (crc_q)
  );

  hf_bit_mux u_mux (
    .field (field_q),
    .idx   (idx_q[3:0]),
    .sfd   (sfd_q),
    .sig   (sig_q),
    .svc   (svc_q),
    .len   (len_q),
    .crc   (crc_q),
    .bit_o (mux_bit)
  );

  assign bit_out    = mux_bit;
  assign bit_valid  = !idle;
  assign hdr_done   = done_q;
  assign crc_status = stat_q;

  // R8: completion strobe is a single cycle with nothing offered
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |-> !bit_valid);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |=> !hdr_done);
  // R7: a refused bit is held
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_out)));
  // R10: status moves only together with the completion strobe
  a_r10_status: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(crc_status) |-> hdr_done);
  // R4: mode 0 never reaches the CRC field
  a_r4_mode0_no_crc: assert property (@(posedge clk) disable iff (!rst_n)
    (field_q == F_CRC) |-> (mode_q != 2'd0));
  // R9: a start during a header does not restart it
  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && start && !bit_ready) |=> $stable(idx_q));

endmodule

// File: tb/hdr_framer_bench.sv
module hdr_framer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [8:0]  cfg_pre_len = '0;
  logic [15:0] cfg_sfd = '0;
  logic [7:0]  cfg_sig_dbpsk = '0;
  logic [7:0]  cfg_sig_dqpsk = '0;
  logic        cfg_mod_sel = 1'b0;
  logic [7:0]  cfg_service = '0;
  logic [15:0] cfg_length = '0;
  logic        start = 1'b0;
  logic        bit_ready = 1'b0;
  logic        bit_out, bit_valid, hdr_done;
  logic [15:0] crc_status;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit ebits [0:600];
  int elen;
  logic [15:0] exp_stat = 16'h0000;
  int hdr_no = 0;

  always #10 clk = ~clk;

  hdr_framer u_hdr_framer (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_pre_len(cfg_pre_len),
    .cfg_sfd(cfg_sfd), .cfg_sig_dbpsk(cfg_sig_dbpsk), .cfg_sig_dqpsk(cfg_sig_dqpsk),
    .cfg_mod_sel(cfg_mod_sel), .cfg_service(cfg_service), .cfg_length(cfg_length),
    .start(start), .bit_ready(bit_ready), .bit_out(bit_out), .bit_valid(bit_valid),
    .hdr_done(hdr_done), .crc_status(crc_status)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (header %0d)", tag, act, exp, hdr_no);
    end
  endtask

  task automatic push(input longint v, input int n, input bit msb_first);
    for (int i = 0; i < n; i++) begin
      ebits[elen] = msb_first ? v[n-1-i] : v[i];
      elen++;
    end
  endtask

  function automatic bit rdy_pat(input int p, input int c);
    case (p)
      0:       return 1'b1;
      1:       return c[0];
      default: return (c % 3) != 1;
    endcase
  endfunction

  task automatic run_hdr(input int mode, input int msel, input int plen, input int pat);
    logic [15:0] sfd, len, r;
    logic [7:0]  sb, sq, sv;
    int got, c, pstart;
    hdr_no++;
    sfd = 16'hF3A0 ^ 16'(hdr_no * 16'h1357);
    sb  = 8'h5C ^ 8'(hdr_no * 3);
    sq  = 8'hA1 ^ 8'(hdr_no * 7);
    sv  = 8'h3E + 8'(hdr_no);
    len = 16'h0123 + 16'(hdr_no * 16'h0B05);
    // Expected stream (R3, R4, R5, R6)
    elen = 0;
    for (int i = 0; i < plen; i++) begin ebits[elen] = 1'b1; elen++; end
    pstart = elen;
    push(sfd, 16, 0);
    if (mode == 3) begin push(msel ? sq : sb, 8, 0); push(sv, 8, 0); end
    if (mode >= 2) push(len, 16, 0);
    if (mode >= 1) begin
      r = 16'hFFFF;
      for (int i = pstart; i < elen; i++)
        r = (r[15] != ebits[i]) ? ((r << 1) ^ 16'h1021) : (r << 1);
      push(~r, 16, 1);
      exp_stat = ~r;
    end
    // Launch (R2)
    @(negedge clk);
    cfg_mode = 2'(mode); cfg_pre_len = 9'(plen); cfg_sfd = sfd;
    cfg_sig_dbpsk = sb; cfg_sig_dqpsk = sq; cfg_mod_sel = msel[0];
    cfg_service = sv; cfg_length = len; start = 1'b1; bit_ready = 1'b0;
    @(posedge clk);
    got = 0; c = 0;
    while (got < elen && c < 3000) begin
      @(negedge clk);
      // R2: scramble configuration after capture
      cfg_mode = ~cfg_mode; cfg_pre_len = 9'(c * 37); cfg_sfd = ~cfg_sfd;
      cfg_sig_dbpsk = 8'(c); cfg_sig_dqpsk = ~cfg_sig_dqpsk; cfg_mod_sel = ~cfg_mod_sel;
      cfg_service = 8'(c * 5); cfg_length = ~cfg_length;
      bit_ready = rdy_pat(pat, c);
      // R9: start raised while the header is busy, incl. the final transfer
      start = (got == elen - 1) ? bit_ready : (c == 2);
      #1;
      if (!bit_valid) begin
        chk(1'b0, "R7 bit_valid dropped early", got, elen);
        got = elen;
      end else if (bit_ready) begin
        chk(bit_out == ebits[got], (got < pstart) ? "R3 preamble bit" : "R4/R5/R6 header bit",
            bit_out, ebits[got]);
        got++;
      end
      c++;
    end
    @(negedge clk);
    start = 1'b0; bit_ready = 1'b0;
    #1;
    chk(hdr_done == 1'b1, "R8 hdr_done after last bit", hdr_done, 1);
    chk(bit_valid == 1'b0, "R8 bit_valid low with hdr_done", bit_valid, 0);
    chk(crc_status == exp_stat, "R10 crc_status", crc_status, exp_stat);
    @(negedge clk);
    #1;
    chk(hdr_done == 1'b0, "R8 hdr_done single cycle", hdr_done, 0);
    chk(bit_valid == 1'b0, "R9 start at last bit ignored", bit_valid, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected < 150000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(bit_valid == 1'b0, "R1 bit_valid in reset", bit_valid, 0);
    chk(hdr_done == 1'b0, "R1 hdr_done in reset", hdr_done, 0);
    chk(crc_status == 16'h0, "R1 crc_status in reset", crc_status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(bit_valid == 1'b0, "R1 idle after reset", bit_valid, 0);
    for (int m = 3; m >= 0; m--)
      for (int s = 0; s < 2; s++)
        foreach (ebits[k]) begin
          if (k > 2) break;
          for (int p = 0; p < 3; p++)
            run_hdr(m, s, (k == 0) ? 0 : ((k == 1) ? 1 : 7), p);
        end
    run_hdr(3, 1, 256, 2);   // R3 longest preamble
    run_hdr(0, 0, 3, 1);     // R10 mode 0 keeps prior status
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule